// File: doc/BRIEF.md
# SPI Slave-Select Timing Controller

This block drives the active-low slave-select line of an SPI master and tells the shift engine when it may clock data. Under software control (manual mode) the line simply mirrors a level bit. Under hardware control (auto mode) the block asserts the select ahead of each transfer, keeps it asserted until just after the last clock edge, and then keeps the slave deselected for a programmable minimum gap before another transfer may begin.

All timing is measured in half periods of the SPI clock. The clock generator provides a one-cycle enable pulse per half period. A 6-bit gap setting `n` gives a deselect time of `n+3` half periods, which is `(n+3)/2` full SPI clock periods. The shift engine raises a request, waits for `ready`, runs its transfer and pulses a done indication on its final edge. A request that arrives while the gap is still running is held off until the gap ends.

Top module: `spi_csel_ctrl`

## Requirements
- R1: While reset is applied, and for the first cycles after it, the select output is high (inactive), `ready` is high, and the controller is in manual mode.
- R2: In manual mode, `ss_n` equals the value `sw_level` had one clock earlier (0 = select active, 1 = inactive) and `ready` is high. `xfer_req` and `xfer_done` have no effect.
- R3: In auto mode with the controller idle, a sampled `xfer_req` drives `ss_n` low and `ready` low on the next clock.
- R4: After the select goes active in auto mode, `ready` rises on the clock that samples the first `half_tick`. Exactly one half period of setup passes.
- R5: After `xfer_done` is sampled, the select stays low through exactly one more `half_tick` and goes high on the clock that samples it.
- R6: After a transfer, `ss_n` stays high for exactly `gap_len+3` half ticks. The value of `gap_len` used is the one sampled when the select goes inactive.
- R7: While the deselect gap runs, `ready` is low and a pending `xfer_req` does not drive the select low.
- R8: A write to `auto_mode` (1 = auto, 0 = manual) takes effect only when the controller is idle. A switch requested during setup, transfer, hold or gap is applied one clock after the gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| auto_mode | input | 1 | 1 = hardware-timed select, 0 = software level |
| sw_level | input | 1 | Manual select level, 0 = active |
| gap_len | input | 6 | Deselect gap setting n, gap = n+3 half periods |
| half_tick | input | 1 | One-cycle pulse per SPI clock half period |
| xfer_req | input | 1 | Shift engine wants to start a transfer |
| xfer_done | input | 1 | Shift engine has produced its last clock edge |
| ss_n | output | 1 | Active-low slave select |
| ready | output | 1 | Shift engine may clock data |

## Verification
The hardest situation to reach from the ports is a mode switch that lands in the middle of an automatic transfer: auto mode must be dropped while the select is active, and the bench must show that setup, hold and the full gap still complete under the old mode. The bench clears `auto_mode` and sets `sw_level` inactive during the running phase of a transfer. It then counts the half ticks that pass before `ready` returns, and checks that the select stayed low through the hold phase. Gap lengths are also exercised at both extremes of the 6-bit setting, and with random settings, transfer lengths and tick spacings from a fixed seed. Every gap is measured with a request already pending.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_SETUP = 3'd1,
    CS_RUN   = 3'd2,
    CS_HOLD  = 3'd3,
    CS_GAP   = 3'd4
  } csel_state_e;
endpackage

// File: rtl/csel_rst_sync.sv
module csel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/csel_gap_timer.sv
module csel_gap_timer #(
  parameter int TMR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             active,
  input  logic             tick,
  output logic             last
);
  logic [TMR_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)
      cnt_nxt = load_val;
    else if (active && tick && (cnt_q != '0))
      cnt_nxt = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign last = active && tick && (cnt_q == TMR_W'(1));
endmodule

// File: rtl/csel_mode_latch.sv
module csel_mode_latch (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  auto_mode,
  input  csel_pkg::csel_state_e st_q,
  input  csel_pkg::csel_state_e st_nxt,
  output logic                  eff_auto_q,
  output logic                  eff_auto_nxt
);
  import csel_pkg::*;

  always_comb begin
    eff_auto_nxt = eff_auto_q;
    if ((st_q == CS_IDLE) && (st_nxt == CS_IDLE))
      eff_auto_nxt = auto_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_auto_q <= 1'b0;
    else        eff_auto_q <= eff_auto_nxt;
  end
endmodule

// File: rtl/csel_seq.sv
module csel_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eff_auto_q,
  input  logic                  eff_auto_nxt,
  input  logic                  sw_level,
  input  logic                  half_tick,
  input  logic                  xfer_req,
  input  logic                  xfer_done,
  input  logic                  gap_last,
  output csel_pkg::csel_state_e st_q,
  output csel_pkg::csel_state_e st_nxt,
  output logic                  gap_load,
  output logic                  ss_n,
  output logic                  ready
);
  import csel_pkg::*;

  logic ss_n_nxt, ready_nxt;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      CS_IDLE:  if (eff_auto_q && xfer_req) st_nxt = CS_SETUP;
      CS_SETUP: if (half_tick)              st_nxt = CS_RUN;
      CS_RUN:   if (xfer_done)              st_nxt = CS_HOLD;
      CS_HOLD:  if (half_tick)              st_nxt = CS_GAP;
      CS_GAP:   if (gap_last)               st_nxt = CS_IDLE;
      default:                              st_nxt = CS_IDLE;
    endcase
  end

  assign gap_load = (st_q == CS_HOLD) && half_tick;

  always_comb begin
    if (eff_auto_nxt) begin
      ss_n_nxt  = !((st_nxt == CS_SETUP) || (st_nxt == CS_RUN) || (st_nxt == CS_HOLD));
      ready_nxt = (st_nxt == CS_RUN);
    end else begin
      ss_n_nxt  = sw_level;
      ready_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      ss_n  <= 1'b1;
      ready <= 1'b1;
    end else begin
      st_q  <= st_nxt;
      ss_n  <= ss_n_nxt;
      ready <= ready_nxt;
    end
  end
endmodule

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic             sw_level,
  input  logic [GAP_W-1:0] gap_len,
  input  logic             half_tick,
  input  logic             xfer_req,
  input  logic             xfer_done,
  output logic             ss_n,
  output logic             ready
);
  import csel_pkg::*;

  localparam int TMR_W = GAP_W + 1;

  logic        rst_sync_n;
  logic        eff_auto_q, eff_auto_nxt;
  logic        gap_load, gap_last, gap_active;
  csel_state_e st_q, st_nxt;
  logic [TMR_W-1:0] gap_load_val;

  csel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  csel_mode_latch u_mode (
    .clk(clk), .rst_n(rst_sync_n), .auto_mode(auto_mode),
    .st_q(st_q), .st_nxt(st_nxt),
    .eff_auto_q(eff_auto_q), .eff_auto_nxt(eff_auto_nxt)
  );

  assign gap_load_val = {1'b0, gap_len} + TMR_W'(3);
  assign gap_active   = (st_q == CS_GAP);

  csel_gap_timer #(.TMR_W(TMR_W)) u_gap (
    .clk(clk), .rst_n(rst_sync_n), .load(gap_load), .load_val(gap_load_val),
    .active(gap_active), .tick(half_tick), .last(gap_last)
  );

  csel_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .eff_auto_q(eff_auto_q), .eff_auto_nxt(eff_auto_nxt),
    .sw_level(sw_level), .half_tick(half_tick),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .gap_last(gap_last),
    .st_q(st_q), .st_nxt(st_nxt), .gap_load(gap_load),
    .ss_n(ss_n), .ready(ready)
  );
endmodule

// File: rtl/spi_csel_chk.sv
module spi_csel_chk #(
  parameter int GAP_W = 6
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  auto_mode,
  input logic                  sw_level,
  input logic [GAP_W-1:0]      gap_len,
  input logic                  half_tick,
  input logic                  xfer_req,
  input logic                  ss_n,
  input logic                  ready,
  input csel_pkg::csel_state_e st_q,
  input logic                  eff_auto_q
);
  import csel_pkg::*;

  localparam int TMR_W = GAP_W + 1;

  logic [TMR_W-1:0] need_q, seen_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      need_q <= '0;
      seen_q <= '0;
    end else if ((st_q == CS_HOLD) && half_tick) begin
      need_q <= {1'b0, gap_len} + TMR_W'(3);
      seen_q <= '0;
    end else if ((st_q == CS_GAP) && half_tick) begin
      seen_q <= seen_q + TMR_W'(1);
    end
  end

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!eff_auto_q && !auto_mode) |=> (ss_n == $past(sw_level)) && ready);

  assert_auto_start_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eff_auto_q && (st_q == CS_IDLE) && xfer_req) |=> (!ss_n && !ready));

  assert_setup_wait_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q == CS_SETUP) && !half_tick) |=> (!ready && !ss_n));

  assert_setup_done_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q == CS_SETUP) && half_tick) |=> (ready && !ss_n));

  assert_gap_end_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q == CS_GAP) && half_tick && (TMR_W'(seen_q + TMR_W'(1)) == need_q)) |=> (st_q == CS_IDLE));

  assert_gap_keep_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q == CS_GAP) && half_tick && (TMR_W'(seen_q + TMR_W'(1)) < need_q)) |=> (st_q == CS_GAP));

  assert_gap_blocked_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == CS_GAP) |-> (ss_n && !ready));

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eff_auto_q && (st_q != CS_IDLE)) |=> eff_auto_q);
endmodule

bind spi_csel_ctrl spi_csel_chk #(.GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .auto_mode(auto_mode), .sw_level(sw_level),
  .gap_len(gap_len), .half_tick(half_tick), .xfer_req(xfer_req),
  .ss_n(ss_n), .ready(ready), .st_q(st_q), .eff_auto_q(eff_auto_q)
);

// File: tb/spi_csel_ctrl_tb_top.sv
module spi_csel_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_mode, sw_level, half_tick, xfer_req, xfer_done;
  logic [5:0] gap_len;
  logic       ss_n, ready;

  int total = 0;
  int bad   = 0;
  int per   = 2;
  int ph    = 0;
  logic cs_s, rdy_s;
  bit   done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_csel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .sw_level(sw_level),
    .gap_len(gap_len), .half_tick(half_tick), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .ss_n(ss_n), .ready(ready)
  );

  function automatic int exp_gap(input int n);
    return n + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample outputs, then set the tick that pairs with the sampled state
  task automatic cyc();
    @(negedge clk);
    cs_s  = ss_n;
    rdy_s = ready;
    ph++;
    if (ph >= per) begin
      half_tick = 1'b1;
      ph = 0;
    end else begin
      half_tick = 1'b0;
    end
  endtask

  task automatic do_xfer(input bit first, input int n, input int len, input bit drop_auto);
    int h = 0, g = 0, s = 0, r = 0;
    gap_len  = 6'(n);
    xfer_req = 1'b1;
    if (!first) begin
      while (cs_s == 1'b0) begin
        if (half_tick) h++;
        cyc();
      end
      chk(h == 1, "R5 hold ticks", h, 1);
    end
    while (cs_s == 1'b1) begin
      if (!first) chk(rdy_s == 1'b0, "R7 ready in gap", rdy_s, 0);
      if (half_tick) g++;
      cyc();
    end
    if (!first) chk(g == exp_gap(n), "R6 gap ticks", g, exp_gap(n));
    chk(rdy_s == 1'b0, "R3 ready after start", rdy_s, 0);
    while (rdy_s == 1'b0) begin
      if (half_tick) s++;
      cyc();
    end
    chk(s == 1, "R4 setup ticks", s, 1);
    xfer_req = 1'b0;
    if (drop_auto) begin
      auto_mode = 1'b0;
      sw_level  = 1'b1;
    end
    while (r < len) begin
      if (rdy_s != 1'b1 || cs_s != 1'b0) chk(0, "R4 run phase", {cs_s, rdy_s}, 1);
      if (half_tick) r++;
      cyc();
    end
    xfer_done = 1'b1;
    cyc();
    xfer_done = 1'b0;
    chk(cs_s == 1'b0 && rdy_s == 1'b0, "R5 hold after done", {cs_s, rdy_s}, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_v, n, len;
    seed_v = $urandom(32'h5eed_c5c5);
    rst_n = 1'b0; auto_mode = 1'b0; sw_level = 1'b1; half_tick = 1'b0;
    xfer_req = 1'b0; xfer_done = 1'b0; gap_len = 6'd0;
    repeat (3) cyc();
    chk(cs_s == 1'b1 && rdy_s == 1'b1, "R1 in reset", {cs_s, rdy_s}, 3);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk(cs_s == 1'b1 && rdy_s == 1'b1, "R1 after reset", {cs_s, rdy_s}, 3);

    // manual mode
    sw_level = 1'b0;
    cyc();
    chk(cs_s == 1'b0, "R2 manual active", cs_s, 0);
    chk(rdy_s == 1'b1, "R2 manual ready", rdy_s, 1);
    xfer_req = 1'b1; xfer_done = 1'b1; sw_level = 1'b1;
    cyc();
    chk(cs_s == 1'b1, "R2 manual ignores req", cs_s, 1);
    repeat (4) cyc();
    chk(cs_s == 1'b1 && rdy_s == 1'b1, "R2 manual steady", {cs_s, rdy_s}, 3);
    xfer_req = 1'b0; xfer_done = 1'b0; sw_level = 1'b0;
    cyc();
    chk(cs_s == 1'b0, "R2 manual low again", cs_s, 0);

    // switch to auto while idle
    auto_mode = 1'b1;
    cyc();
    chk(cs_s == 1'b1 && rdy_s == 1'b0, "R8 idle switch to auto", {cs_s, rdy_s}, 2);
    xfer_done = 1'b1;
    cyc();
    xfer_done = 1'b0;
    cyc();
    chk(cs_s == 1'b1 && rdy_s == 1'b0, "R3 idle ignores done", {cs_s, rdy_s}, 2);

    // directed corners
    per = 2;
    do_xfer(1, 0, 1, 0);
    do_xfer(0, 0, 1, 0);
    do_xfer(0, 63, 3, 0);
    per = 5;
    do_xfer(0, 63, 2, 0);
    do_xfer(0, 1, 4, 0);

    // random traffic
    for (int i = 0; i < 30; i++) begin
      per = 2 + int'($urandom_range(3));
      n   = int'($urandom_range(63));
      len = 1 + int'($urandom_range(7));
      do_xfer(0, n, len, 0);
    end

    // mode drop during a running transfer
    per = 3;
    do_xfer(0, 5, 3, 1);
    begin
      int h = 0, g = 0;
      while (cs_s == 1'b0) begin
        if (half_tick) h++;
        cyc();
      end
      chk(h == 1, "R8 hold kept after mode drop", h, 1);
      while (rdy_s == 1'b0) begin
        if (cs_s != 1'b1) chk(0, "R8 select in deferred gap", cs_s, 1);
        if (half_tick) g++;
        cyc();
      end
      chk(g == exp_gap(5), "R8 gap kept after mode drop", g, exp_gap(5));
      chk(cs_s == 1'b1, "R8 manual level after gap", cs_s, 1);
    end
    sw_level = 1'b0;
    cyc();
    chk(cs_s == 1'b0 && rdy_s == 1'b1, "R8 manual in effect", {cs_s, rdy_s}, 1);

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule